// File: doc/BRIEF.md
# Serial Peripheral Controller with Frame Parity

This block is the controller side of a four-wire synchronous serial link. Software or a neighbouring engine presents a data word and pulses a write strobe. The block pulls the select line low, generates the serial clock from the system clock through a programmable divider, and shifts a frame out on the data-out line while it samples the data-in line. When the frame ends it presents the received word with a one-cycle valid strobe.

The frame carries between 4 and 16 data bits. The data bits go out most-significant or least-significant first. When parity is on, one more bit follows the data in either bit order. Even or odd parity can be chosen, and a parity mismatch on the received frame raises a sticky error flag. Only the low bits of the written word that fit the programmed length are used, so a narrow value is carried with zeros above it. Clock polarity and clock phase follow the usual four-wire conventions.

Top module: `spi_par_ctrl`

## Requirements
- R1: A frame carries cfgLen data bits (4 to 16), plus one bit when cfgParEn=1. It produces exactly two serial clock edges per frame bit.
- R2: A txWrite pulse while busy is low starts a frame. A txWrite pulse while busy is high is ignored, and the frame in progress keeps its data.
- R3: Only txData bits below cfgLen are sent and enter the parity. Bits at or above cfgLen have no effect on the wire.
- R4: With cfgLsbFirst=1, txData bit 0 is sent first and the first received bit lands in rxData bit 0. With cfgLsbFirst=0, bit cfgLen-1 is first in both directions.
- R5: With cfgParEn=1, the parity bit is the last frame bit in either order. For even parity (cfgParOdd=0) it is the XOR of the data bits. For odd parity it is the inverse of that XOR.
- R6: A received frame whose last bit disagrees with the parity of its received data sets parErr. parErr stays set until a parErrClr pulse. A set in the same cycle wins over a clear.
- R7: rxValid pulses for one cycle after all frame bits have been sampled. rxData then holds the received data bits right-aligned, with zeros above cfgLen.
- R8: While idle, sclk equals cfgCpol. Each sclk half-period lasts cfgDiv+1 system clock cycles, and sclk is back at its idle level when the frame ends.
- R9: With cfgCpha=0, the first bit is on mosi before the first edge, miso is sampled on odd edges, and mosi changes on even edges. With cfgCpha=1, mosi changes on odd edges and miso is sampled on even edges.
- R10: csN falls one half-period before the first sclk edge and rises one half-period after the last edge. busy is high exactly while csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgLen | input | 5 | Data bits per frame, 4 to 16 |
| cfgLsbFirst | input | 1 | 1: least-significant bit first |
| cfgParEn | input | 1 | Append and check a parity bit |
| cfgParOdd | input | 1 | 1: odd parity, 0: even parity |
| cfgCpol | input | 1 | Idle level of sclk |
| cfgCpha | input | 1 | 0: sample on odd edges, 1: on even edges |
| cfgDiv | input | 8 | Half-period length minus one, in system clocks |
| txWrite | input | 1 | Start strobe carrying txData |
| txData | input | 16 | Word to send |
| parErrClr | input | 1 | Clears the sticky parity error |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low select |
| busy | output | 1 | Frame in progress |
| rxData | output | 16 | Last received word |
| rxValid | output | 1 | One-cycle strobe for rxData |
| parErr | output | 1 | Sticky parity error |

## Verification
The bench builds the block with its defaults: a 16-bit maximum frame and an 8-bit divider. This puts both the shortest 4-bit frame and the full 17-bit frame with parity within reach. The divider is kept between 0 and 3 so that many frames fit in a short run, and a divider of 0 exercises the one-cycle half-period, where clock and data change on consecutive system clocks. A bench slave model drives miso by clock phase and occasionally corrupts the parity bit. Lead and trail timing and the edge count are measured on the wires.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic sclkEdge;
    logic sample;
    logic shift;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/spi_par_seq.sv
module spi_par_seq
  import spi_par_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txWrite,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgParEn,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [DIV_W-1:0] cfgDiv,
  output seqStrobe_t       strb,
  output logic             sclk,
  output logic             csN,
  output logic             busy
);

  localparam int CNT_W = LEN_W + 2;

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divQ;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] edgeTotal;
  logic [CNT_W-1:0] edgeNum;
  logic             cphaQ;
  logic             cpolQ;
  logic             sclkR;
  logic             tick;

  assign tick    = (divCnt == divQ);
  assign edgeNum = edgeCnt + 1'b1;

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && txWrite;
    strb.sclkEdge = (state == ST_SHIFT) && tick;
    strb.sample   = strb.sclkEdge && (edgeNum[0] != cphaQ);
    strb.shift    = strb.sclkEdge && (edgeNum[0] == cphaQ) && (edgeNum != edgeTotal);
    strb.finish   = (state == ST_TRAIL) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      divQ      <= '0;
      edgeCnt   <= '0;
      edgeTotal <= '0;
      cphaQ     <= 1'b0;
      cpolQ     <= 1'b0;
      sclkR     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclkR <= cfgCpol;
          if (txWrite) begin
            state     <= ST_SHIFT;
            divCnt    <= '0;
            edgeCnt   <= '0;
            divQ      <= cfgDiv;
            cphaQ     <= cfgCpha;
            cpolQ     <= cfgCpol;
            edgeTotal <= {(CNT_W-LEN_W-1)'(0), cfgLen, 1'b0} + {(CNT_W-2)'(0), cfgParEn, 1'b0};
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            divCnt  <= '0;
            sclkR   <= ~sclkR;
            edgeCnt <= edgeNum;
            if (edgeNum == edgeTotal) state <= ST_TRAIL;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = ~busy;
  assign sclk = busy ? sclkR : cfgCpol;

  // R1: frame ends after exactly two edges per bit
  a_r1_edge_total: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (edgeCnt == edgeTotal));

  // R8: clock rests at the latched idle level at frame end
  a_r8_sclk_rests: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (sclkR == cpolQ));

  // R2: a write during a frame does not end it
  a_r2_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txWrite && !strb.finish) |=> busy);

  // R10: no clock edge outside an active select
  a_r10_edge_in_select: assert property (@(posedge clk) disable iff (!rstN)
    strb.sclkEdge |-> !csN);

endmodule

// File: rtl/spi_par_dp.sv
module spi_par_dp
  import spi_par_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [MAX_LEN-1:0] txData,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic               cfgLsbFirst,
  input  logic               cfgParEn,
  input  logic               cfgParOdd,
  input  logic               cfgCpha,
  input  logic               miso,
  input  logic               parErrClr,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rxData,
  output logic               rxValid,
  output logic               parErr
);

  localparam int FRAME_W = MAX_LEN + 1;
  localparam int SREG_W  = FRAME_W + 1;
  localparam int IDX_W   = $clog2(MAX_LEN);

  logic [FRAME_W-1:0] txFrame;
  logic               txPar;
  logic [SREG_W-1:0]  txSh;
  logic [FRAME_W-1:0] rxSeq;
  logic [LEN_W-1:0]   sampCnt;
  logic [LEN_W-1:0]   lenQ;
  logic               lsbQ;
  logic               parEnQ;
  logic               parOddQ;
  logic [MAX_LEN-1:0] rxWord;
  logic               rxParExp;

  // transmit frame: element k is the k-th bit on the wire
  always_comb begin
    txPar   = cfgParOdd;
    txFrame = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (k < int'(cfgLen)) txPar = txPar ^ txData[k];
    end
    for (int k = 0; k < FRAME_W; k++) begin
      int srcIdx;
      srcIdx = int'(cfgLen) - 1 - k;
      if (k < int'(cfgLen)) begin
        txFrame[k] = cfgLsbFirst ? txData[IDX_W'(k)] : txData[IDX_W'(srcIdx)];
      end else if ((k == int'(cfgLen)) && cfgParEn) begin
        txFrame[k] = txPar;
      end
    end
  end

  // receive reconstruction from arrival order
  always_comb begin
    rxWord   = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      int srcIdx;
      srcIdx = int'(lenQ) - 1 - k;
      if (k < int'(lenQ)) begin
        rxWord[k] = lsbQ ? rxSeq[k] : rxSeq[LEN_W'(srcIdx)];
      end
    end
    rxParExp = parOddQ ^ (^rxWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSeq   <= '0;
      sampCnt <= '0;
      lenQ    <= '0;
      lsbQ    <= 1'b0;
      parEnQ  <= 1'b0;
      parOddQ <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.load) begin
        txSh    <= cfgCpha ? {txFrame, 1'b0} : {1'b0, txFrame};
        sampCnt <= '0;
        rxSeq   <= '0;
        lenQ    <= cfgLen;
        lsbQ    <= cfgLsbFirst;
        parEnQ  <= cfgParEn;
        parOddQ <= cfgParOdd;
      end
      if (strb.shift) txSh <= txSh >> 1;
      if (strb.sample) begin
        rxSeq[sampCnt] <= miso;
        sampCnt        <= sampCnt + 1'b1;
      end
      if (strb.finish) begin
        rxData  <= rxWord;
        rxValid <= 1'b1;
      end
      if (strb.finish && parEnQ && (rxSeq[lenQ] != rxParExp)) begin
        parErr <= 1'b1;
      end else if (parErrClr) begin
        parErr <= 1'b0;
      end
    end
  end

  assign mosi = txSh[0];

  // R7: valid only once every frame bit has been sampled
  a_r7_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (sampCnt == (lenQ + LEN_W'(parEnQ))));

  // R6: error flag holds without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !parErrClr) |=> parErr);

  // R6: flag rises only at the end of a parity frame
  a_r6_rise_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErr) |-> ($past(strb.finish) && parEnQ));

endmodule

// File: rtl/spi_par_ctrl.sv
module spi_par_ctrl
  import spi_par_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic               cfgLsbFirst,
  input  logic               cfgParEn,
  input  logic               cfgParOdd,
  input  logic               cfgCpol,
  input  logic               cfgCpha,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic               txWrite,
  input  logic [MAX_LEN-1:0] txData,
  input  logic               parErrClr,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               csN,
  output logic               busy,
  output logic [MAX_LEN-1:0] rxData,
  output logic               rxValid,
  output logic               parErr
);

  seqStrobe_t strb;

  spi_par_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W)) seq_i (
    .clk     (clk),
    .rstN    (rstN),
    .txWrite (txWrite),
    .cfgLen  (cfgLen),
    .cfgParEn(cfgParEn),
    .cfgCpol (cfgCpol),
    .cfgCpha (cfgCpha),
    .cfgDiv  (cfgDiv),
    .strb    (strb),
    .sclk    (sclk),
    .csN     (csN),
    .busy    (busy)
  );

  spi_par_dp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .txData     (txData),
    .cfgLen     (cfgLen),
    .cfgLsbFirst(cfgLsbFirst),
    .cfgParEn   (cfgParEn),
    .cfgParOdd  (cfgParOdd),
    .cfgCpha    (cfgCpha),
    .miso       (miso),
    .parErrClr  (parErrClr),
    .mosi       (mosi),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .parErr     (parErr)
  );

endmodule

// File: tb/spi_par_ctrl_tb_top.sv
module spi_par_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cfgLen = 5'd8;
  logic        cfgLsbFirst = 1'b0;
  logic        cfgParEn = 1'b0;
  logic        cfgParOdd = 1'b0;
  logic        cfgCpol = 1'b0;
  logic        cfgCpha = 1'b0;
  logic [7:0]  cfgDiv = 8'd0;
  logic        txWrite = 1'b0;
  logic [15:0] txData = '0;
  logic        parErrClr = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, mosi, csN, busy, rxValid, parErr;
  logic [15:0] rxData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit expParErr = 1'b0;
  bit done = 1'b0;

  // slave model state
  logic [16:0] slvSeq = '0;
  logic [16:0] capSeq = '0;
  int          edgeNo = 0;
  int          capCnt = 0;
  time         tFall, tFirst, tLast, tRise;

  spi_par_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cfgLen(cfgLen), .cfgLsbFirst(cfgLsbFirst),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .cfgDiv(cfgDiv), .txWrite(txWrite), .txData(txData),
    .parErrClr(parErrClr), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN),
    .busy(busy), .rxData(rxData), .rxValid(rxValid), .parErr(parErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cycles++;

  function automatic logic [16:0] wireSeq(input logic [15:0] d, input int len,
                                           input bit lsb, input bit pen, input bit odd);
    logic [16:0] s = '0;
    bit p = odd;
    for (int k = 0; k < len; k++) p ^= d[k];
    for (int k = 0; k < len; k++) s[k] = lsb ? d[k] : d[len-1-k];
    if (pen) s[len] = p;
    return s;
  endfunction

  function automatic logic [16:0] lowMask(input int n);
    logic [16:0] m = '0;
    for (int k = 0; k < n; k++) m[k] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // slave: track select and clock edges
  always @(negedge csN) begin
    tFall  = $time;
    edgeNo = 0;
    capCnt = 0;
    capSeq = '0;
    if (!cfgCpha) miso = slvSeq[0];
  end

  always @(posedge csN) tRise = $time;

  always @(sclk) begin
    if (rstN && !csN) begin
      edgeNo++;
      if (edgeNo == 1) tFirst = $time;
      tLast = $time;
      if (((edgeNo % 2) == 1) != cfgCpha) begin
        if (capCnt < 17) capSeq[capCnt] = mosi;
        capCnt++;
      end else begin
        int idx;
        idx = cfgCpha ? (edgeNo - 1) / 2 : edgeNo / 2;
        if (idx < 17) miso = slvSeq[idx];
      end
    end
  end

  task automatic runFrame(input logic [15:0] d, input int len, input bit lsb,
                          input bit pen, input bit odd, input bit cpol, input bit cpha,
                          input int div, input logic [15:0] rdat, input bit corrupt,
                          input bit tryOverwrite);
    int nb;
    int w;
    logic [16:0] expTx;
    nb = len + (pen ? 1 : 0);
    @(negedge clk);
    cfgLen = 5'(len); cfgLsbFirst = lsb; cfgParEn = pen; cfgParOdd = odd;
    cfgCpol = cpol; cfgCpha = cpha; cfgDiv = 8'(div);
    slvSeq = wireSeq(rdat, len, lsb, pen, odd);
    if (corrupt && pen) slvSeq[len] = ~slvSeq[len];
    @(negedge clk);
    @(negedge clk);
    chk(sclk == cpol, "R8", "idle sclk", sclk, cpol);
    txData = d; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    chk(busy && !csN, "R10", "busy/csN after start", {busy, csN}, 2'b10);
    if (tryOverwrite) begin
      txData = ~d; txWrite = 1'b1;
      @(negedge clk);
      txWrite = 1'b0;
    end
    w = 0;
    while (!rxValid && w < 2000) begin @(posedge clk); w++; end
    @(negedge clk);
    expTx = wireSeq(d, len, lsb, pen, odd);
    if (corrupt && pen) expParErr = 1'b1;
    chk(edgeNo == 2 * nb, "R1", "edge count", edgeNo, 2 * nb);
    chk((capSeq & lowMask(nb)) == expTx, tryOverwrite ? "R2" : "R4",
        "mosi frame", capSeq & lowMask(nb), expTx);
    chk(rxData == (rdat & 16'(lowMask(len))), "R7", "rxData",
        rxData, rdat & 16'(lowMask(len)));
    chk(parErr == expParErr, "R6", "parErr", parErr, expParErr);
    chk(tFirst - tFall == time'((div + 1) * CLK_PERIOD), "R10", "lead time",
        tFirst - tFall, (div + 1) * CLK_PERIOD);
    chk(tRise - tLast == time'((div + 1) * CLK_PERIOD), "R10", "trail time",
        tRise - tLast, (div + 1) * CLK_PERIOD);
    chk(!busy && csN && !rxValid, "R7", "single valid pulse, idle",
        {busy, csN, rxValid}, 3'b010);
    chk(sclk == cpol, "R8", "sclk back at idle", sclk, cpol);
  endtask

  task automatic clearErr();
    @(negedge clk);
    parErrClr = 1'b1;
    @(negedge clk);
    parErrClr = 1'b0;
    expParErr = 1'b0;
    chk(parErr == 1'b0, "R6", "parErr after clear", parErr, 0);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN && !busy && !rxValid && !parErr, "R10", "reset state",
        {csN, busy, rxValid, parErr}, 4'b1000);
    chk(sclk == cfgCpol, "R8", "reset sclk", sclk, cfgCpol);

    // R4 MSB-first, R9 phase 0, no parity
    runFrame(16'h00A5, 8, 0, 0, 0, 0, 0, 0, 16'h003C, 0, 0);
    // R4 LSB-first, R9 phase 1, polarity 1
    runFrame(16'h00A5, 8, 1, 0, 0, 1, 1, 2, 16'h00C3, 0, 0);
    // R3 upper bits ignored, shortest frame, R5 even parity
    runFrame(16'hFFF6, 4, 0, 1, 0, 0, 1, 1, 16'hFFF9, 0, 0);
    // R5 odd parity on full 16-bit frame, LSB-first
    runFrame(16'h8001, 16, 1, 1, 1, 1, 0, 3, 16'h7FFE, 0, 0);
    // R6 corrupted parity sets flag, stays set over a good frame
    runFrame(16'h0123, 12, 0, 1, 0, 0, 0, 0, 16'h0456, 1, 0);
    runFrame(16'h0055, 8, 1, 1, 1, 0, 1, 0, 16'h00AA, 0, 0);
    clearErr();
    // R2 write during a frame is ignored
    runFrame(16'h5A5A, 16, 0, 0, 0, 0, 0, 2, 16'h1234, 0, 1);
    // R3 upper-bit noise alone: sent frame equals the masked value
    runFrame(16'hFF00, 5, 1, 1, 1, 1, 1, 0, 16'hFFE0, 0, 0);

    for (int i = 0; i < 40; i++) begin
      int len;
      bit pen, cor;
      len = 4 + int'($urandom % 13);
      pen = 1'($urandom);
      cor = pen && (($urandom % 4) == 0);
      runFrame(16'($urandom), len, 1'($urandom), pen, 1'($urandom),
               1'($urandom), 1'($urandom), int'($urandom % 4),
               16'($urandom), cor, (($urandom % 8) == 0));
      if (expParErr && (($urandom % 2) == 0)) clearErr();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule